// File: doc/BRIEF.md
# Shift-Chain Configuration Loader

This block writes a configuration cell array through two families of shift chains. The bit-line chain of each region carries the data for one row. The word-line chain of each region selects the row. The data arrives as a stream of one-bit-per-region samples on a valid/ready input. For every configuration word the loader first takes one sample per bit-line position, then one sample per word-line position. It then spends a single cycle programming, and every region whose row selection is valid latches its bit-line chain into the selected row.

A fixed number of words makes up the whole load. When the last word has been programmed, the loader stays finished and refuses input until reset. A region whose word-line chain does not hold exactly one set bit at programming time is skipped for that word, and a sticky error flag is raised. The cell array here is a behavioural stand-in, and it can be read one bit at a time through a combinational port so that the loaded image can be checked.

Top module: `cfg_chain_loader`

## Requirements
- R1: During reset and in the first cycle after it, `in_ready`, `done`, `cfg_error`, `prog_strobe`, both shift outputs and the whole cell array read 0. In the cycle after that, the block is ready for bit-line samples.
- R2: In the bit-line phase, the block accepts exactly `BL_LEN` samples. `bl_shift` is high only in a cycle where `in_valid` and `in_ready` are both high.
- R3: In the word-line phase, the block accepts exactly `WL_LEN` samples. `wl_shift` is high only on an accepted sample. The word-line phase never starts before the bit-line phase of the same word is complete.
- R4: `bl_shift` and `wl_shift` are never high in the same cycle.
- R5: Bit `r` of `in_data` feeds region `r`. The k-th accepted bit-line sample of a word (counting from 0) ends up in column `BL_LEN-1-k` of the row that is written.
- R6: The k-th accepted word-line sample of a word ends up at row position `WL_LEN-1-k`. Programming copies the region's bit-line chain into the row whose word-line bit is set. All other rows are unchanged.
- R7: `prog_strobe` is high for exactly one cycle. That cycle directly follows the cycle that accepted the last word-line sample. `in_ready` is low during it.
- R8: During the programming cycle, `prog_mask[r]` is 1 exactly when region `r`'s word-line chain holds exactly one set bit. A region whose mask bit is 0 is not written. `prog_mask` is 0 outside the programming cycle.
- R9: `cfg_error` rises in the cycle after a programming cycle in which any `prog_mask` bit was 0. It then stays high until reset.
- R10: After `WORD_COUNT` programming cycles, `done` is high and `in_ready` is low. Later `in_valid` pulses shift nothing and leave the array unchanged until reset.
- R11: `rd_bit` gives, combinationally, the cell at (`rd_region`, `rd_row`, `rd_col`). It is 0 for an address outside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_ready | output | 1 | Loader is in a shift phase and takes the sample |
| in_data | input | NUM_REGIONS | One chain-head bit per region |
| bl_shift | output | 1 | Bit-line chains advance this cycle |
| wl_shift | output | 1 | Word-line chains advance this cycle |
| prog_strobe | output | 1 | Programming cycle of the current word |
| prog_mask | output | NUM_REGIONS | Per-region write enable during programming |
| cfg_error | output | 1 | Sticky flag for a region skipped because its row selection was not one-hot |
| done | output | 1 | All words programmed |
| rd_region | input | RG_W | Readback region index |
| rd_row | input | ROW_W | Readback row index |
| rd_col | input | COL_W | Readback column index |
| rd_bit | output | 1 | Readback cell value |

## Verification
The bench builds the block with two regions, a 5-position bit-line chain, a 4-position word-line chain and six words. With these values a full load takes under a hundred cycles. The gaps in `in_valid` land on phase boundaries, and every row of both regions can be read back afterwards. Two words carry a corrupt word-line pattern: one region with no bit set, and another with two bits set. These exercise the suppressed write and the sticky error without growing the run. The bench keeps driving after completion to show that the finished state holds.

// File: rtl/cfg_chain_pkg.sv
// Shared definitions for the shift-chain configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SHIFT_BL = 3'd1,
        ST_SHIFT_WL = 3'd2,
        ST_PROGRAM  = 3'd3,
        ST_DONE     = 3'd4
    } ld_state_t;

endpackage

// File: rtl/cfg_chain_ctrl.sv
// Sequencer of the loader. For each word it walks bit-line shifting,
// then word-line shifting, then one programming cycle. It stops after
// WORD_COUNT words.
// Assumes: BL_LEN, WL_LEN >= 2 and WORD_COUNT >= 1; synchronous active-low reset.
module cfg_chain_ctrl
    import cfg_chain_pkg::*;
#(
    parameter int BL_LEN     = 39,
    parameter int WL_LEN     = 37,
    parameter int WORD_COUNT = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic bl_shift,
    output logic wl_shift,
    output logic prog_strobe,
    output logic done
);

    localparam int POS_MAX = (BL_LEN > WL_LEN) ? BL_LEN : WL_LEN;
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam int WORD_W  = $clog2(WORD_COUNT + 1);

    ld_state_t         state_q;
    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] word_q;
    logic              accept;

    // Handshake and per-phase strobes decoded from the state.
    always_comb begin
        in_ready    = (state_q == ST_SHIFT_BL) || (state_q == ST_SHIFT_WL);
        accept      = in_valid && in_ready;
        bl_shift    = accept && (state_q == ST_SHIFT_BL);
        wl_shift    = accept && (state_q == ST_SHIFT_WL);
        prog_strobe = (state_q == ST_PROGRAM);
        done        = (state_q == ST_DONE);
    end

    // State, chain-position and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_q <= ST_SHIFT_BL;
                    pos_q   <= '0;
                end
                ST_SHIFT_BL: if (accept) begin
                    if (pos_q == POS_W'(BL_LEN - 1)) begin
                        pos_q   <= '0;
                        state_q <= ST_SHIFT_WL;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                ST_SHIFT_WL: if (accept) begin
                    if (pos_q == POS_W'(WL_LEN - 1)) begin
                        pos_q   <= '0;
                        state_q <= ST_PROGRAM;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                ST_PROGRAM: begin
                    if (word_q == WORD_W'(WORD_COUNT - 1)) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_SHIFT_BL;
                    end
                    word_q <= word_q + 1'b1;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_shift_chain.sv
// One family of shift chains, one chain per region. When shift_en is
// high, each chain takes its head bit at position 0 and moves every bit
// one position up.
// Assumes: LEN >= 2.
module cfg_shift_chain #(
    parameter int NUM_REGIONS = 2,
    parameter int LEN         = 39
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic [NUM_REGIONS-1:0] head,
    output logic [LEN-1:0]       chain [NUM_REGIONS]
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic [LEN-1:0] bits_q;

        // Shift this region's chain on an enabled cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (shift_en) begin
                bits_q <= {bits_q[LEN-2:0], head[r]};
            end
        end

        assign chain[r] = bits_q;
    end

endmodule

// File: rtl/cfg_cell_array.sv
// Behavioural configuration cell array. During programming, every
// enabled region copies its bit-line chain into the rows that its
// word-line chain selects. A combinational port reads back single cells.
// Assumes: the caller enables a region only when its row selection is one-hot.
module cfg_cell_array #(
    parameter int NUM_REGIONS = 2,
    parameter int BL_LEN      = 39,
    parameter int WL_LEN      = 37,
    parameter int RG_W        = 2,
    parameter int ROW_W       = 6,
    parameter int COL_W       = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prog_strobe,
    input  logic [NUM_REGIONS-1:0] wr_mask,
    input  logic [BL_LEN-1:0]      bl_data [NUM_REGIONS],
    input  logic [WL_LEN-1:0]      wl_data [NUM_REGIONS],
    input  logic [RG_W-1:0]        rd_region,
    input  logic [ROW_W-1:0]       rd_row,
    input  logic [COL_W-1:0]       rd_col,
    output logic                   rd_bit
);

    logic [WL_LEN-1:0][BL_LEN-1:0] region_rows [NUM_REGIONS];

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic [WL_LEN-1:0][BL_LEN-1:0] rows_q;

        // Latch the bit-line chain into the selected row of this region.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows_q <= '0;
            end else if (prog_strobe && wr_mask[r]) begin
                for (int w = 0; w < WL_LEN; w++) begin
                    if (wl_data[r][w]) rows_q[w] <= bl_data[r];
                end
            end
        end

        assign region_rows[r] = rows_q;
    end

    logic [BL_LEN-1:0] sel_row;

    // Combinational single-cell readback; 0 outside the array.
    always_comb begin
        sel_row = '0;
        rd_bit  = 1'b0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            for (int w = 0; w < WL_LEN; w++) begin
                if (rd_region == RG_W'(r) && rd_row == ROW_W'(w)) sel_row = region_rows[r][w];
            end
        end
        for (int c = 0; c < BL_LEN; c++) begin
            if (rd_col == COL_W'(c)) rd_bit = sel_row[c];
        end
    end

endmodule

// File: rtl/cfg_chain_loader.sv
// Top of the shift-chain configuration loader. It ties the sequencer,
// the bit-line and word-line chain families and the cell array model
// together. It gates each region's write on a one-hot row selection and
// keeps the sticky error flag.
// Assumes: synchronous active-low reset; BL_LEN, WL_LEN >= 2.
module cfg_chain_loader #(
    parameter int NUM_REGIONS = 2,
    parameter int BL_LEN      = 39,
    parameter int WL_LEN      = 37,
    parameter int WORD_COUNT  = 36,
    localparam int RG_W       = $clog2(NUM_REGIONS + 1),
    localparam int ROW_W      = $clog2(WL_LEN + 1),
    localparam int COL_W      = $clog2(BL_LEN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NUM_REGIONS-1:0] in_data,
    output logic                   bl_shift,
    output logic                   wl_shift,
    output logic                   prog_strobe,
    output logic [NUM_REGIONS-1:0] prog_mask,
    output logic                   cfg_error,
    output logic                   done,
    input  logic [RG_W-1:0]        rd_region,
    input  logic [ROW_W-1:0]       rd_row,
    input  logic [COL_W-1:0]       rd_col,
    output logic                   rd_bit
);

    logic [BL_LEN-1:0]      bl_chain [NUM_REGIONS];
    logic [WL_LEN-1:0]      wl_chain [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] row_ok;

    cfg_chain_ctrl #(
        .BL_LEN(BL_LEN), .WL_LEN(WL_LEN), .WORD_COUNT(WORD_COUNT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .bl_shift(bl_shift), .wl_shift(wl_shift),
        .prog_strobe(prog_strobe), .done(done)
    );

    cfg_shift_chain #(.NUM_REGIONS(NUM_REGIONS), .LEN(BL_LEN)) u_bl_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(bl_shift), .head(in_data), .chain(bl_chain)
    );

    cfg_shift_chain #(.NUM_REGIONS(NUM_REGIONS), .LEN(WL_LEN)) u_wl_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(wl_shift), .head(in_data), .chain(wl_chain)
    );

    // Per-region one-hot test of the row selection.
    always_comb begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
            row_ok[r] = $onehot(wl_chain[r]);
        end
        prog_mask = prog_strobe ? row_ok : '0;
    end

    // Sticky flag for a region skipped during programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_error <= 1'b0;
        end else if (prog_strobe && !(&row_ok)) begin
            cfg_error <= 1'b1;
        end
    end

    cfg_cell_array #(
        .NUM_REGIONS(NUM_REGIONS), .BL_LEN(BL_LEN), .WL_LEN(WL_LEN),
        .RG_W(RG_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .prog_strobe(prog_strobe), .wr_mask(prog_mask),
        .bl_data(bl_chain), .wl_data(wl_chain),
        .rd_region(rd_region), .rd_row(rd_row), .rd_col(rd_col), .rd_bit(rd_bit)
    );

endmodule

// File: rtl/cfg_chain_loader_chk.sv
// Protocol checker for the loader. It watches only the top-level ports
// and counts shifts per word with counters of its own.
// Assumes: attached by the bind statement at the end of this file.
module cfg_chain_loader_chk #(
    parameter int NUM_REGIONS = 2,
    parameter int BL_LEN      = 39,
    parameter int WL_LEN      = 37
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   bl_shift,
    input logic                   wl_shift,
    input logic                   prog_strobe,
    input logic [NUM_REGIONS-1:0] prog_mask,
    input logic                   cfg_error,
    input logic                   done
);

    int bl_seen;
    int wl_seen;

    // Count the shifts of the current word; restart after programming.
    always_ff @(posedge clk) begin
        if (!rst_n || prog_strobe) begin
            bl_seen <= 0;
            wl_seen <= 0;
        end else begin
            if (bl_shift) bl_seen <= bl_seen + 1;
            if (wl_shift) wl_seen <= wl_seen + 1;
        end
    end

    a_r2_bl_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        bl_shift |-> (in_valid && in_ready));
    a_r2_bl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bl_shift |-> (bl_seen < BL_LEN));
    a_r3_wl_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wl_shift |-> (in_valid && in_ready));
    a_r3_bl_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_shift && wl_seen == 0) |-> (bl_seen == BL_LEN));
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bl_shift && wl_shift));
    a_r7_chains_full: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |-> (bl_seen == BL_LEN && wl_seen == WL_LEN && !in_ready));
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |=> !prog_strobe);
    a_r8_mask_in_program: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mask != '0) |-> prog_strobe);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !in_ready && !bl_shift && !wl_shift));

endmodule

bind cfg_chain_loader cfg_chain_loader_chk #(
    .NUM_REGIONS(NUM_REGIONS), .BL_LEN(BL_LEN), .WL_LEN(WL_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .bl_shift(bl_shift), .wl_shift(wl_shift), .prog_strobe(prog_strobe),
    .prog_mask(prog_mask), .cfg_error(cfg_error), .done(done)
);

// File: tb/cfg_chain_loader_tb.sv
// Self-checking bench: behavioural queue model compared on every clock.
module cfg_chain_loader_tb;

    localparam int NR = 2;
    localparam int BL = 5;
    localparam int WL = 4;
    localparam int WC = 6;
    localparam int RG_W  = $clog2(NR + 1);
    localparam int ROW_W = $clog2(WL + 1);
    localparam int COL_W = $clog2(BL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [NR-1:0] in_data = '0;
    logic bl_shift, wl_shift, prog_strobe, cfg_error, done, rd_bit;
    logic [NR-1:0] prog_mask;
    logic [RG_W-1:0]  rd_region = '0;
    logic [ROW_W-1:0] rd_row = '0;
    logic [COL_W-1:0] rd_col = '0;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // Reference model state
    int ph = 0;          // 0 idle, 1 bit-line, 2 word-line, 3 program, 4 done
    int word = 0;
    bit m_err = 0;
    logic [NR-1:0] qb[$];
    logic [NR-1:0] qw[$];
    bit m_arr [NR][WL][BL];

    always #4 clk = ~clk;

    cfg_chain_loader #(.NUM_REGIONS(NR), .BL_LEN(BL), .WL_LEN(WL), .WORD_COUNT(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .bl_shift(bl_shift), .wl_shift(wl_shift), .prog_strobe(prog_strobe),
        .prog_mask(prog_mask), .cfg_error(cfg_error), .done(done),
        .rd_region(rd_region), .rd_row(rd_row), .rd_col(rd_col), .rd_bit(rd_bit)
    );

    task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
        end
    endtask

    // Stream sample s: word = s/(BL+WL); bit-line samples first, then word-line.
    function automatic logic [NR-1:0] sample(int s);
        int w = s / (BL + WL);
        int p = s % (BL + WL);
        logic [NR-1:0] v = '0;
        if (w >= WC) return '1;
        for (int r = 0; r < NR; r++) begin
            if (p < BL) begin
                v[r] = ((w * 3 + p * 5 + r * 7) % 4) < 2;
            end else begin
                int k = p - BL;
                int t = (w + r) % WL;
                v[r] = (WL - 1 - k == t);
                if (w == 2 && r == 1) v[r] = 1'b0;                       // no row selected
                if (w == 4 && r == 0) v[r] = v[r] || (WL - 1 - k == (t + 1) % WL); // two rows
            end
        end
        return v;
    endfunction

    function automatic int ones_in_wl(int r);
        int n = 0;
        foreach (qw[k]) if (qw[k][r]) n++;
        return n;
    endfunction

    task automatic model_step();
        bit acc;
        if (!rst_n) begin
            ph = 0; word = 0; m_err = 0;
            qb.delete(); qw.delete();
            foreach (m_arr[r, w, c]) m_arr[r][w][c] = 0;
            return;
        end
        acc = in_valid && (ph == 1 || ph == 2);
        case (ph)
            0: ph = 1;
            1: if (acc) begin qb.push_back(in_data); if (qb.size() == BL) ph = 2; end
            2: if (acc) begin qw.push_back(in_data); if (qw.size() == WL) ph = 3; end
            3: begin
                for (int r = 0; r < NR; r++) begin
                    if (ones_in_wl(r) == 1) begin
                        int row = 0;
                        foreach (qw[k]) if (qw[k][r]) row = WL - 1 - k;
                        foreach (qb[k]) m_arr[r][row][BL - 1 - k] = qb[k][r];
                    end else begin
                        m_err = 1;
                    end
                end
                qb.delete(); qw.delete();
                word++;
                ph = (word == WC) ? 4 : 1;
            end
            default: ;
        endcase
    endtask

    task automatic compare_all();
        string t;
        logic [NR-1:0] em;
        bit rdy;
        rdy = (ph == 1 || ph == 2);
        em = '0;
        if (ph == 3) for (int r = 0; r < NR; r++) em[r] = (ones_in_wl(r) == 1);
        t = (!rst_n || ph == 0) ? "R1" : "";
        chk({t, " R2 R7 R10"}, "in_ready", in_ready, rdy);
        chk({t, " R2"}, "bl_shift", bl_shift, rdy && ph == 1 && in_valid);
        chk({t, " R3"}, "wl_shift", wl_shift, rdy && ph == 2 && in_valid);
        chk("R4", "shift_overlap", bl_shift & wl_shift, 0);
        chk({t, " R7"}, "prog_strobe", prog_strobe, ph == 3);
        chk("R8", "prog_mask", prog_mask, em);
        chk({t, " R9"}, "cfg_error", cfg_error, m_err);
        chk({t, " R10"}, "done", done, ph == 4);
        chk("R11", "rd_bit_0_0_0", rd_bit, m_arr[0][0][0]);
    endtask

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int s = 0;
        int cyc = 0;
        int tail = 0;
        // Reset phase (R1)
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rst_n = 1'b0; in_valid = (i == 1);
            #1 compare_all();
            @(posedge clk); model_step();
        end
        // Main load, including post-completion stimulus (R10)
        while (tail < 12 && cyc < 2000) begin
            @(negedge clk);
            rst_n = 1'b1;
            in_valid = (cyc % 5 != 3) || (ph == 4);
            in_data = sample(s);
            #1 compare_all();
            if (in_valid && (ph == 1 || ph == 2)) s++;
            @(posedge clk); model_step();
            if (ph == 4) tail++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        // Full readback of the array (R5 R6 R8 R11)
        for (int r = 0; r < NR; r++) begin
            for (int w = 0; w < WL; w++) begin
                for (int c = 0; c < BL; c++) begin
                    rd_region = RG_W'(r); rd_row = ROW_W'(w); rd_col = COL_W'(c);
                    #1 chk("R5 R6 R8", "cell", rd_bit, m_arr[r][w][c]);
                end
            end
        end
        rd_region = RG_W'(NR); rd_row = '0; rd_col = '0;
        #1 chk("R11", "out_of_range", rd_bit, 0);
        rd_region = '0;
        chk("R9", "error_seen", cfg_error, 1);
        // Reset clears done and the error (R1 R9 R10)
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); model_step();
        @(negedge clk);
        #1 compare_all();
        rst_n = 1'b1;
        @(posedge clk); model_step();
        @(negedge clk);
        #1 compare_all();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule